// File: doc/BRIEF.md
# Erase Timeout and Status Bit Generator

This block produces the progress status that a flash erase controller presents on its data bus when software polls it. An erase confirm opens an accumulation window, and the erase engine does not start until that window has run out. A further confirm for a block in the same bank restarts the window. A confirm that names a block in the other bank cancels the whole operation. While the erase runs, the block builds a data-polling bit, two toggle bits, an error bit and a timer bit. A suspend request is honoured after a fixed, bounded number of cycles.

The status read strobe `rd_i` comes with `rd_erasing_i`, which tells the block whether the addressed block is one of those being erased. The toggle bits change on status reads, not on clock edges. The value presented during a read is the value before that read's flip. A model of the erase engine reports completion on `done_i`, and `fail_i` gives the outcome at that moment. The timeout and the suspend latency are set in microseconds and converted to clock cycles using `CLK_MHZ`. The array contents are handled outside this block.

The controller has six states:
- IDLE: no operation.
- WINDOW: the accumulation timeout is running.
- ERASING: the engine is running.
- SUSP_PEND: a suspend has been requested and its latency is counting.
- SUSPENDED: the erase is paused.
- FAILED: the erase ended with an error.

The transitions are:
- start: IDLE to WINDOW.
- extend: WINDOW to WINDOW, when a confirm names the same bank.
- cross-bank abort: WINDOW to IDLE.
- reset abort: WINDOW to IDLE.
- expiry: WINDOW to ERASING.
- suspend: ERASING to SUSP_PEND.
- settle: SUSP_PEND to SUSPENDED.
- resume: SUSPENDED to ERASING.
- complete: ERASING or SUSP_PEND to IDLE.
- fail: ERASING or SUSP_PEND to FAILED.
- clear: FAILED to IDLE.

Top module: `erase_status_gen`

## Requirements
- R1: After reset the block is in IDLE. `busy_o` is 0 and `array_o` is 1. `stat_o` is 8'h80. The status byte layout is: bit 7 is the polling bit, bit 6 is the run toggle, bit 5 is the error bit, bit 3 is the timer bit and bit 2 is the suspend toggle. Bits 4, 1 and 0 always read 0.
- R2: A start strobe in IDLE enters WINDOW. There, bit 7 and bit 3 read 0 and `busy_o` is 1. If nothing else happens, the block reaches ERASING exactly WINDOW_US*CLK_MHZ clock edges after the start edge. From then on, bit 3 reads 1.
- R3: An add strobe in WINDOW whose `bank_i` equals the bank latched at start reloads the window. ERASING then begins WINDOW_US*CLK_MHZ edges after the add edge.
- R4: A status read (`rd_i`) in WINDOW, ERASING, SUSP_PEND or FAILED inverts bit 6 after its edge. Bit 6 does not change without such a read, and it does not change on reads in IDLE.
- R5: `done_i` in ERASING or SUSP_PEND goes to IDLE when `fail_i` is 0, where bit 7 reads 1. When `fail_i` is 1 it goes to FAILED, where bit 5 reads 1 and bit 7 reads 0. FAILED is left only through `reset_cmd_i`, which returns to IDLE.
- R6: A suspend strobe in ERASING enters SUSP_PEND. After exactly SUSP_US*CLK_MHZ edges the block moves to SUSPENDED.
- R7: In SUSPENDED, bit 6 reads 1. `array_o` is 1 when `rd_erasing_i` is 0, and 0 when it is 1.
- R8: An add strobe in WINDOW whose `bank_i` differs from the latched bank aborts the operation and returns to IDLE.
- R9: `reset_cmd_i` in WINDOW aborts to IDLE. In ERASING it has no effect. A suspend strobe in WINDOW has no effect.
- R10: A resume strobe in SUSPENDED returns to ERASING, where `array_o` reads 0 again.
- R11: A read with `rd_erasing_i` at 1 inverts bit 2 after its edge in WINDOW, ERASING, SUSP_PEND and SUSPENDED. Other reads leave bit 2 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | First erase confirm strobe |
| add_i | input | 1 | Additional erase confirm strobe |
| bank_i | input | 1 | Bank of the block named by a confirm |
| reset_cmd_i | input | 1 | Read/reset command strobe |
| suspend_i | input | 1 | Erase suspend strobe |
| resume_i | input | 1 | Erase resume strobe |
| rd_i | input | 1 | Status read strobe |
| rd_erasing_i | input | 1 | Addressed block is being erased |
| done_i | input | 1 | Engine finished |
| fail_i | input | 1 | Engine outcome was a failure (valid with done_i) |
| stat_o | output | 8 | Status byte |
| busy_o | output | 1 | An operation is in progress |
| array_o | output | 1 | A read at this point returns array data |

## Verification
The bench hits the window boundary on the exact edge. A counter that is off by one would show bit 3 rising one cycle early or late. A late add that fails to restart the window would start the erase after about 100 cycles instead of 150. A cross-bank add, or a reset issued during the window, must drop `busy_o`, and a design that merged these cases with the same-bank path would keep running. During suspend, the bench checks that `array_o` stays low for exactly the latency, that bit 6 is forced high, and that bit 2 flips only on reads of erasing blocks. After a failure, bit 5 must persist until the reset command. Random strobes and reads then drive a reference model through every transition, which exposes toggles that flip on clocks or in the wrong states.

// File: rtl/esg_pkg.sv
package esg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WINDOW,
        ST_ERASING,
        ST_SUSP_PEND,
        ST_SUSPENDED,
        ST_FAILED
    } esg_state_t;
endpackage

// File: rtl/esg_countdown.sv
module esg_countdown #(
    parameter int LEN = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic zero_o
);
    localparam int CW = (LEN < 2) ? 1 : $clog2(LEN);
    localparam logic [CW-1:0] RELOAD = CW'(LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= RELOAD;
        else if (run_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/esg_toggle.sv
module esg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_i,
    input  logic rd_erasing_i,
    input  logic run_en_i,
    input  logic susp_en_i,
    output logic run_tog_o,
    output logic susp_tog_o
);
    logic run_flip, susp_flip;

    assign run_flip  = rd_i && run_en_i;
    assign susp_flip = rd_i && rd_erasing_i && susp_en_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_tog_o  <= 1'b0;
            susp_tog_o <= 1'b0;
        end else begin
            if (run_flip)  run_tog_o  <= ~run_tog_o;
            if (susp_flip) susp_tog_o <= ~susp_tog_o;
        end
    end

    assert_run_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_i && run_en_i) |=> $stable(run_tog_o));
    assert_run_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && run_en_i) |=> (run_tog_o != $past(run_tog_o)));
    assert_susp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_i && rd_erasing_i && susp_en_i) |=> $stable(susp_tog_o));
endmodule

// File: rtl/esg_fsm.sv
module esg_fsm
    import esg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       add_i,
    input  logic       bank_i,
    input  logic       reset_cmd_i,
    input  logic       suspend_i,
    input  logic       resume_i,
    input  logic       done_i,
    input  logic       fail_i,
    input  logic       win_zero_i,
    input  logic       sus_zero_i,
    output esg_state_t state_o,
    output logic       win_load_o,
    output logic       sus_load_o
);
    esg_state_t state_q, state_d;
    logic       bank_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bank_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i)
                bank_q <= bank_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (start_i) state_d = ST_WINDOW;
            ST_WINDOW:
                if (reset_cmd_i)                  state_d = ST_IDLE;
                else if (add_i && bank_i != bank_q) state_d = ST_IDLE;
                else if (add_i)                   state_d = ST_WINDOW;
                else if (win_zero_i)              state_d = ST_ERASING;
            ST_ERASING:
                if (done_i)         state_d = fail_i ? ST_FAILED : ST_IDLE;
                else if (suspend_i) state_d = ST_SUSP_PEND;
            ST_SUSP_PEND:
                if (done_i)          state_d = fail_i ? ST_FAILED : ST_IDLE;
                else if (sus_zero_i) state_d = ST_SUSPENDED;
            ST_SUSPENDED:
                if (resume_i) state_d = ST_ERASING;
            ST_FAILED:
                if (reset_cmd_i) state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        state_o    = state_q;
        win_load_o = (state_q == ST_IDLE && start_i) ||
                     (state_q == ST_WINDOW && !reset_cmd_i && add_i && bank_i == bank_q);
        sus_load_o = (state_q == ST_ERASING && suspend_i && !done_i);
    end

    assert_no_early_erase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WINDOW && !win_zero_i) |=> (state_q != ST_ERASING));
    assert_failed_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAILED && !reset_cmd_i) |=> (state_q == ST_FAILED));
    assert_erase_ignores_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASING && reset_cmd_i && !done_i) |=> (state_q != ST_IDLE));
    assert_resume_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSPENDED && resume_i) |=> (state_q == ST_ERASING));
endmodule

// File: rtl/erase_status_gen.sv
module erase_status_gen
    import esg_pkg::*;
#(
    parameter int CLK_MHZ   = 200,
    parameter int WINDOW_US = 100,
    parameter int SUSP_US   = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       add_i,
    input  logic       bank_i,
    input  logic       reset_cmd_i,
    input  logic       suspend_i,
    input  logic       resume_i,
    input  logic       rd_i,
    input  logic       rd_erasing_i,
    input  logic       done_i,
    input  logic       fail_i,
    output logic [7:0] stat_o,
    output logic       busy_o,
    output logic       array_o
);
    localparam int WIN_CYC = (CLK_MHZ * WINDOW_US < 1) ? 1 : CLK_MHZ * WINDOW_US;
    localparam int SUS_CYC = (CLK_MHZ * SUSP_US < 1) ? 1 : CLK_MHZ * SUSP_US;

    esg_state_t st;
    logic win_load, sus_load, win_zero, sus_zero;
    logic run_tog, susp_tog, run_en, susp_en;

    esg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .add_i(add_i), .bank_i(bank_i),
        .reset_cmd_i(reset_cmd_i), .suspend_i(suspend_i), .resume_i(resume_i),
        .done_i(done_i), .fail_i(fail_i),
        .win_zero_i(win_zero), .sus_zero_i(sus_zero),
        .state_o(st), .win_load_o(win_load), .sus_load_o(sus_load)
    );

    esg_countdown #(.LEN(WIN_CYC)) u_win_cnt (
        .clk(clk), .rst_n(rst_n), .load_i(win_load),
        .run_i(st == ST_WINDOW), .zero_o(win_zero)
    );

    esg_countdown #(.LEN(SUS_CYC)) u_sus_cnt (
        .clk(clk), .rst_n(rst_n), .load_i(sus_load),
        .run_i(st == ST_SUSP_PEND), .zero_o(sus_zero)
    );

    assign run_en  = (st == ST_WINDOW) || (st == ST_ERASING) ||
                     (st == ST_SUSP_PEND) || (st == ST_FAILED);
    assign susp_en = (st == ST_WINDOW) || (st == ST_ERASING) ||
                     (st == ST_SUSP_PEND) || (st == ST_SUSPENDED);

    esg_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .rd_erasing_i(rd_erasing_i),
        .run_en_i(run_en), .susp_en_i(susp_en),
        .run_tog_o(run_tog), .susp_tog_o(susp_tog)
    );

    always_comb begin
        stat_o    = '0;
        stat_o[2] = susp_tog;
        stat_o[6] = run_tog;
        busy_o    = (st != ST_IDLE);
        array_o   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                stat_o[7] = 1'b1;
                array_o   = 1'b1;
            end
            ST_WINDOW: ;
            ST_ERASING, ST_SUSP_PEND:
                stat_o[3] = 1'b1;
            ST_SUSPENDED: begin
                stat_o[3] = 1'b1;
                stat_o[6] = 1'b1;
                array_o   = !rd_erasing_i;
            end
            ST_FAILED: begin
                stat_o[3] = 1'b1;
                stat_o[5] = 1'b1;
            end
        endcase
    end

    logic [31:0] pend_cyc;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pend_cyc <= '0;
        else if (st == ST_SUSP_PEND) pend_cyc <= pend_cyc + 1'b1;
        else                        pend_cyc <= '0;
    end

    assert_susp_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUSP_PEND) |-> (pend_cyc < 32'(SUS_CYC)));
    assert_idle_polling_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (stat_o[7] && !stat_o[5]));
endmodule

// File: tb/erase_status_gen_test.sv
`timescale 1ns/1ps
module erase_status_gen_test;
    localparam int MHZ = 1, WUS = 100, SUS = 15;
    localparam int W = MHZ * WUS, S = MHZ * SUS;
    localparam int I = 0, WN = 1, ER = 2, SP = 3, SU = 4, FA = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic start = 0, add = 0, bank = 0, rcmd = 0, susp = 0, res = 0;
    logic rd = 0, rd_er = 0, done = 0, fail = 0;
    logic [7:0] stat;
    logic busy, arr;

    erase_status_gen #(.CLK_MHZ(MHZ), .WINDOW_US(WUS), .SUSP_US(SUS)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .add_i(add), .bank_i(bank),
        .reset_cmd_i(rcmd), .suspend_i(susp), .resume_i(res), .rd_i(rd),
        .rd_erasing_i(rd_er), .done_i(done), .fail_i(fail),
        .stat_o(stat), .busy_o(busy), .array_o(arr)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    int ms = I, rem = 0;
    logic m6 = 0, m2 = 0, mbank = 0;

    function logic [7:0] exp_stat();
        case (ms)
            I:  return {1'b1, m6, 1'b0, 1'b0, 1'b0, m2, 2'b00};
            WN: return {1'b0, m6, 1'b0, 1'b0, 1'b0, m2, 2'b00};
            ER, SP: return {1'b0, m6, 1'b0, 1'b0, 1'b1, m2, 2'b00};
            SU: return {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, m2, 2'b00};
            default: return {1'b0, m6, 1'b1, 1'b0, 1'b1, m2, 2'b00};
        endcase
    endfunction

    function string tag_of();
        case (ms)
            I: return "R1"; WN: return "R2"; ER: return "R4";
            SP: return "R6"; SU: return "R7"; default: return "R5";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic t6, t2;
        t6 = rd && (ms == WN || ms == ER || ms == SP || ms == FA);
        t2 = rd && rd_er && (ms == WN || ms == ER || ms == SP || ms == SU);
        case (ms)
            I: if (start) begin ms = WN; rem = W; mbank = bank; end
            WN: begin
                if (rcmd) ms = I;
                else if (add && bank != mbank) ms = I;
                else if (add) rem = W;
                else begin rem--; if (rem == 0) ms = ER; end
            end
            ER: begin
                if (done) ms = fail ? FA : I;
                else if (susp) begin ms = SP; rem = S; end
            end
            SP: begin
                if (done) ms = fail ? FA : I;
                else begin rem--; if (rem == 0) ms = SU; end
            end
            SU: if (res) ms = ER;
            default: if (rcmd) ms = I;
        endcase
        if (t6) m6 = ~m6;
        if (t2) m2 = ~m2;
    endtask

    task automatic cyc();
        #1;
        chk(tag_of(), {24'd0, stat}, {24'd0, exp_stat()});
        chk("R9", {30'd0, busy, arr}, {30'd0, ms != I, (ms == I) || (ms == SU && !rd_er)});
        @(posedge clk);
        model_step();
        @(negedge clk);
        start = 0; add = 0; rcmd = 0; susp = 0; res = 0; rd = 0; done = 0; fail = 0;
    endtask

    task automatic wait_cyc(int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    logic s6, s2;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", {24'd0, stat}, 32'h80);
        chk("R1", {30'd0, busy, arr}, 32'h1);

        // window length and suspend ignored inside it
        start = 1; bank = 0; cyc();
        susp = 1; cyc();
        wait_cyc(W - 2);
        chk("R2", {31'd0, stat[3]}, 0);
        chk("R9", {31'd0, busy}, 1);
        cyc();
        chk("R2", {30'd0, stat[7], stat[3]}, 32'h1);

        // read toggling
        s6 = stat[6];
        rd = 1; rd_er = 0; cyc();
        chk("R4", {31'd0, stat[6]}, {31'd0, ~s6});
        cyc();
        chk("R4", {31'd0, stat[6]}, {31'd0, ~s6});

        // reset ignored while erasing
        rcmd = 1; cyc();
        chk("R9", {30'd0, busy, stat[3]}, 32'h3);

        // suspend latency
        susp = 1; cyc();
        wait_cyc(S - 1);
        chk("R6", {31'd0, arr}, 0);
        cyc();
        chk("R6", {31'd0, arr}, 1);
        rd_er = 1; #1;
        chk("R7", {30'd0, stat[6], arr}, 32'h2);
        s2 = stat[2];
        rd = 1; cyc();
        chk("R11", {31'd0, stat[2]}, {31'd0, ~s2});
        rd_er = 0; rd = 1; cyc();
        chk("R11", {31'd0, stat[2]}, {31'd0, ~s2});
        chk("R7", {31'd0, arr}, 1);

        // resume
        res = 1; cyc();
        chk("R10", {29'd0, arr, busy, stat[3]}, 32'h3);

        // failure path
        done = 1; fail = 1; cyc();
        chk("R5", {30'd0, stat[5], stat[7]}, 32'h2);
        wait_cyc(5);
        chk("R5", {31'd0, stat[5]}, 1);
        rcmd = 1; cyc();
        chk("R5", {29'd0, busy, stat[5], stat[7]}, 32'h1);

        // success path and frozen toggle
        start = 1; cyc(); wait_cyc(W);
        done = 1; fail = 0; cyc();
        chk("R5", {30'd0, busy, stat[7]}, 32'h1);
        s6 = stat[6];
        rd = 1; cyc();
        chk("R4", {31'd0, stat[6]}, {31'd0, s6});

        // restart by same-bank add
        start = 1; bank = 1; cyc();
        wait_cyc(49);
        add = 1; bank = 1; cyc();
        wait_cyc(W - 1);
        chk("R3", {31'd0, stat[3]}, 0);
        cyc();
        chk("R3", {31'd0, stat[3]}, 1);
        done = 1; cyc();

        // cross-bank abort
        start = 1; bank = 0; cyc(); wait_cyc(10);
        add = 1; bank = 1; cyc();
        chk("R8", {31'd0, busy}, 0);

        // reset abort inside window
        start = 1; bank = 0; cyc(); wait_cyc(5);
        rcmd = 1; cyc();
        chk("R9", {31'd0, busy}, 0);

        // random phase
        void'($urandom(32'h5EED_0123));
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom % 100;
            bank  = ($urandom % 4) == 0 ? ~mbank : mbank;
            rd    = ($urandom % 3) == 0;
            rd_er = $urandom % 2;
            if (r < 4) start = 1;
            else if (r < 5) add = 1;
            else if (r < 7) rcmd = 1;
            else if (r < 11) susp = 1;
            else if (r < 15) res = 1;
            else if (r < 17) begin done = 1; fail = $urandom % 2; end
            cyc();
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule